// File: doc/BRIEF.md
# 8-bit ALU with Status Flag Register

This block is the datapath heart of a small microcontroller core. Each cycle it combines a working-register operand with a second operand (taken from a file register or an instruction literal) under a 3-bit operation code. It produces an 8-bit result on a combinational output. On the next clock edge it folds the arithmetic flags of that operation into a status register.

Subtraction is an addition of the two's complement of the subtrahend. Carry and digit carry therefore end up holding inverted borrows. The rotates move bits through the carry flag.

The same status register also records two power-management bits: a time-out bit and a power-down bit. External strobes drive them for sleep, watchdog clear and watchdog time-out. Software can read the whole register and can overwrite the five arithmetic flags directly. The instruction decoder, the register file and the watchdog counter sit outside this block.

Top module: `alu8_status`

## Requirements
- R1: After reset the status register reads 0x60: time-out (bit 6) and power-down (bit 5) are 1, bit 7 and flags N (bit 4), OV (bit 3), Z (bit 2), DC (bit 1), C (bit 0) are 0.
- R2: With `alu_op` 0 the result is `opnd + wreg`, with 1 it is `opnd - wreg`, with 2 it is `wreg - opnd`, all modulo 256, and the subtractions are formed as an add of the two's complement.
- R3: For codes 0 to 2, C takes the carry out of bit 7 and DC the carry out of bit 3 of that addition, so on subtraction a 1 means no borrow.
- R4: For codes 0 to 2, OV takes the XOR of the carry into bit 7 and the carry out of bit 7.
- R5: For every code, Z is set exactly when the 8-bit result is zero and N equals result bit 7.
- R6: Codes 3 (AND), 4 (inclusive OR) and 5 (exclusive OR) combine `wreg` with `opnd` and leave C, DC and OV unchanged.
- R7: Code 6 rotates `opnd` right through carry (old C enters bit 7, bit 0 goes to C), code 7 rotates left through carry (old C enters bit 0, bit 7 goes to C); both leave DC and OV unchanged.
- R8: A software write changes only bits 4..0; time-out and power-down are unaffected and bit 7 always reads 0.
- R9: When a software write and an operation fall in the same cycle, each flag the operation updates takes the operation's value, and every other flag takes the written value.
- R10: A watchdog time-out clears time-out; otherwise sleep or watchdog clear sets it. Sleep clears power-down; otherwise watchdog clear sets it.
- R11: With no operation, write or event strobe the status register holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset (power-up) |
| alu_en | input | 1 | Commit the flags of the current operation at the clock edge |
| alu_op | input | 3 | Operation code |
| wreg | input | 8 | Working-register operand |
| opnd | input | 8 | File-register or literal operand |
| result | output | 8 | Combinational operation result |
| sw_we | input | 1 | Software write strobe for the status register |
| sw_wdata | input | 8 | Software write data |
| ev_sleep | input | 1 | Sleep instruction executed |
| ev_wdt_clr | input | 1 | Watchdog-clear instruction executed |
| ev_wdt_tmo | input | 1 | Watchdog time-out occurred |
| status | output | 8 | Status register contents |

## Verification
A software write to the status register and an operation that updates flags can land in the same cycle. The bench provokes this by raising `sw_we` together with `alu_en`. It uses a logic operation, so that C, DC and OV must come from the written byte while Z and N come from the result. It also uses an addition, where all five flags must come from the operation. In a further cycle, time-out and sleep strobes arrive together, and the bench checks that both power bits end cleared.

// File: rtl/alu8_status.sv
module alu8_status #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         alu_en,
  input  logic [2:0]   alu_op,
  input  logic [W-1:0] wreg,
  input  logic [W-1:0] opnd,
  output logic [W-1:0] result,
  input  logic         sw_we,
  input  logic [7:0]   sw_wdata,
  input  logic         ev_sleep,
  input  logic         ev_wdt_clr,
  input  logic         ev_wdt_tmo,
  output logic [7:0]   status
);
  localparam int HALF = W / 2;

  logic         to_q, pd_q;
  logic [4:0]   flg_q, flg_d;
  logic         to_d, pd_d;

  logic         is_sub, is_arith, is_logic, is_rot;
  logic [W-1:0] a_in, b_in, b_eff;
  logic [W:0]   sum_full;
  logic [HALF:0] sum_lo;
  logic [W-1:0] sum_hi7;
  logic         c_out, dc_out, c_into_msb, ov_out;
  logic         rot_c;

  assign is_sub   = (alu_op == 3'd1) || (alu_op == 3'd2);
  assign is_arith = (alu_op <= 3'd2);
  assign is_logic = (alu_op >= 3'd3) && (alu_op <= 3'd5);
  assign is_rot   = (alu_op >= 3'd6);

  assign a_in  = (alu_op == 3'd2) ? wreg : opnd;
  assign b_in  = (alu_op == 3'd2) ? opnd : wreg;
  assign b_eff = is_sub ? ~b_in : b_in;

  assign sum_full = {1'b0, a_in} + {1'b0, b_eff} + {{W{1'b0}}, is_sub};
  assign sum_lo   = {1'b0, a_in[HALF-1:0]} + {1'b0, b_eff[HALF-1:0]} + {{HALF{1'b0}}, is_sub};
  assign sum_hi7  = {1'b0, a_in[W-2:0]} + {1'b0, b_eff[W-2:0]} + {{(W-1){1'b0}}, is_sub};

  assign c_out      = sum_full[W];
  assign dc_out     = sum_lo[HALF];
  assign c_into_msb = sum_hi7[W-1];
  assign ov_out     = c_into_msb ^ c_out;
  assign rot_c      = (alu_op == 3'd6) ? opnd[0] : opnd[W-1];

  always_comb begin
    case (alu_op)
      3'd3:    result = wreg & opnd;
      3'd4:    result = wreg | opnd;
      3'd5:    result = wreg ^ opnd;
      3'd6:    result = {flg_q[0], opnd[W-1:1]};
      3'd7:    result = {opnd[W-2:0], flg_q[0]};
      default: result = sum_full[W-1:0];
    endcase
  end

  always_comb begin
    flg_d = flg_q;
    if (sw_we) flg_d = sw_wdata[4:0];
    if (alu_en) begin
      flg_d[4] = result[W-1];
      flg_d[2] = (result == '0);
      if (is_arith) begin
        flg_d[3] = ov_out;
        flg_d[1] = dc_out;
        flg_d[0] = c_out;
      end else if (is_rot) begin
        flg_d[0] = rot_c;
      end
    end
  end

  always_comb begin
    to_d = to_q;
    pd_d = pd_q;
    if (ev_wdt_tmo)                to_d = 1'b0;
    else if (ev_sleep || ev_wdt_clr) to_d = 1'b1;
    if (ev_sleep)                  pd_d = 1'b0;
    else if (ev_wdt_clr)           pd_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      to_q  <= 1'b1;
      pd_q  <= 1'b1;
      flg_q <= '0;
    end else begin
      to_q  <= to_d;
      pd_q  <= pd_d;
      flg_q <= flg_d;
    end
  end

  assign status = {1'b0, to_q, pd_q, flg_q};

  logic unused_logic;
  assign unused_logic = is_logic ^ (^sw_wdata[7:5]);
endmodule

// File: rtl/alu8_status_chk.sv
module alu8_status_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         alu_en,
  input logic [2:0]   alu_op,
  input logic [W-1:0] result,
  input logic         sw_we,
  input logic         ev_sleep,
  input logic         ev_wdt_clr,
  input logic         ev_wdt_tmo,
  input logic [7:0]   status
);
  assert_msb_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    status[7] == 1'b0);

  assert_tmo_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wdt_tmo |=> !status[6]);

  assert_sleep_clears_pd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sleep |=> !status[5]);

  assert_zero_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    alu_en |=> status[2] == ($past(result) == '0));

  assert_neg_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    alu_en |=> status[4] == $past(result[W-1]));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!alu_en && !sw_we && !ev_sleep && !ev_wdt_clr && !ev_wdt_tmo) |=> $stable(status));

  assert_write_keeps_power_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_we && !ev_sleep && !ev_wdt_clr && !ev_wdt_tmo) |=> $stable(status[6:5]));

  assert_logic_keeps_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_en && !sw_we && alu_op >= 3'd3 && alu_op <= 3'd5) |=> $stable(status[3:0] & 4'b1011));
endmodule

bind alu8_status alu8_status_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .alu_en(alu_en), .alu_op(alu_op), .result(result),
  .sw_we(sw_we), .ev_sleep(ev_sleep), .ev_wdt_clr(ev_wdt_clr),
  .ev_wdt_tmo(ev_wdt_tmo), .status(status)
);

// File: tb/tb_alu8_status.sv
module tb_alu8_status;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       alu_en = 0;
  logic [2:0] alu_op = 0;
  logic [7:0] wreg = 0, opnd = 0;
  logic [7:0] result;
  logic       sw_we = 0;
  logic [7:0] sw_wdata = 0;
  logic       ev_sleep = 0, ev_wdt_clr = 0, ev_wdt_tmo = 0;
  logic [7:0] status;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  alu8_status dut (
    .clk(clk), .rst_n(rst_n), .alu_en(alu_en), .alu_op(alu_op),
    .wreg(wreg), .opnd(opnd), .result(result), .sw_we(sw_we),
    .sw_wdata(sw_wdata), .ev_sleep(ev_sleep), .ev_wdt_clr(ev_wdt_clr),
    .ev_wdt_tmo(ev_wdt_tmo), .status(status)
  );

  // {op, wreg, opnd, carry preset, expected result, expected N OV Z DC C}
  localparam logic [32:0] VEC [14] = '{
    {3'd0, 8'h0F, 8'h01, 1'b0, 8'h10, 5'h02},
    {3'd0, 8'h80, 8'h80, 1'b0, 8'h00, 5'h0D},
    {3'd0, 8'h01, 8'h7F, 1'b0, 8'h80, 5'h1A},
    {3'd1, 8'h03, 8'h05, 1'b0, 8'h02, 5'h03},
    {3'd1, 8'h05, 8'h03, 1'b0, 8'hFE, 5'h10},
    {3'd2, 8'h44, 8'h44, 1'b0, 8'h00, 5'h07},
    {3'd2, 8'h80, 8'h01, 1'b0, 8'h7F, 5'h09},
    {3'd3, 8'hF0, 8'h0F, 1'b1, 8'h00, 5'h05},
    {3'd4, 8'h80, 8'h01, 1'b0, 8'h81, 5'h10},
    {3'd5, 8'hAA, 8'hAA, 1'b1, 8'h00, 5'h05},
    {3'd6, 8'h00, 8'h01, 1'b0, 8'h00, 5'h05},
    {3'd6, 8'h00, 8'h02, 1'b1, 8'h81, 5'h10},
    {3'd7, 8'h00, 8'h80, 1'b0, 8'h00, 5'h05},
    {3'd7, 8'h00, 8'h40, 1'b1, 8'h81, 5'h10}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic sw_write(input logic [7:0] d);
    @(negedge clk);
    sw_we = 1; sw_wdata = d;
    @(negedge clk);
    sw_we = 0;
  endtask

  task automatic pulse(input bit sl, input bit clr, input bit tmo);
    @(negedge clk);
    ev_sleep = sl; ev_wdt_clr = clr; ev_wdt_tmo = tmo;
    @(negedge clk);
    ev_sleep = 0; ev_wdt_clr = 0; ev_wdt_tmo = 0;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset status", status, 8'h60);

    for (int i = 0; i < 14; i++) begin
      sw_write({7'b0, VEC[i][13]});
      alu_op = VEC[i][32:30]; wreg = VEC[i][29:22]; opnd = VEC[i][21:14];
      alu_en = 1;
      #1;
      check($sformatf("R2/R6/R7 result vec %0d", i), result, VEC[i][12:5]);
      @(negedge clk);
      alu_en = 0;
      check($sformatf("R3/R4/R5 flags vec %0d", i), {3'b0, status[4:0]}, {3'b0, VEC[i][4:0]});
    end

    // R7: rotate keeps DC and OV
    sw_write(8'h0A);
    @(negedge clk); alu_op = 3'd6; opnd = 8'h03; alu_en = 1;
    @(negedge clk); alu_en = 0;
    check("R7 rotate keeps DC/OV", {3'b0, status[4:0]}, 8'h0B);

    // R8: write only touches low flags
    sw_write(8'hFF);
    check("R8 write all ones", status, 8'h7F);
    sw_write(8'h00);
    check("R8 write zeros", status, 8'h60);

    // R11: idle hold
    repeat (3) @(negedge clk);
    check("R11 idle hold", status, 8'h60);

    // R9: write with logic op: C/DC/OV from write, Z/N from result
    @(negedge clk);
    sw_we = 1; sw_wdata = 8'h1F; alu_en = 1; alu_op = 3'd3; wreg = 8'h01; opnd = 8'h01;
    @(negedge clk);
    sw_we = 0; alu_en = 0;
    check("R9 write+logic", {3'b0, status[4:0]}, 8'h0B);
    // R9: write with add: operation wins every flag
    @(negedge clk);
    sw_we = 1; sw_wdata = 8'h1F; alu_en = 1; alu_op = 3'd0; wreg = 8'h01; opnd = 8'h02;
    @(negedge clk);
    sw_we = 0; alu_en = 0;
    check("R9 write+add", {3'b0, status[4:0]}, 8'h00);

    // R10: power bits
    pulse(1, 0, 0);
    check("R10 sleep", status[7:5], 3'b010);
    pulse(0, 0, 1);
    check("R10 timeout", status[7:5], 3'b000);
    pulse(0, 1, 0);
    check("R10 wdt clear", status[7:5], 3'b011);
    pulse(1, 0, 1);
    check("R10 timeout+sleep", status[7:5], 3'b000);
    pulse(1, 1, 0);
    check("R10 sleep+clear", status[7:5], 3'b010);

    // R1: reset again restores power bits and flags
    sw_write(8'h1F);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    check("R1 re-reset", status, 8'h60);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule